// File: doc/BRIEF.md
# Privileged Status Register with Supervisor Window

This block holds the processor's privileged status word. It has two ways in through one register access port. The machine window sees the whole word. The supervisor window is a masked alias of the same storage. It shows only the supervisor-visible fields. Its writes are merged into the current contents and then go through the machine write rules, so both windows share one legality path.

The register holds:
- the interrupt-enable bits and the previous-interrupt-enable bits for two privilege levels;
- the previous-privilege fields;
- the floating-point and extension context-state fields;
- the modify-privilege bit;
- the protect-user-memory bit;
- the address-translation mode field.

The translation mode field takes only supported encodings. Any write that changes a field which affects address translation raises a one-cycle request to flush the translation cache. The bus that decodes register instructions and the trap entry and return sequencing are outside this block. The translation cache that takes the flush request is also outside it.

Top module: `priv_status_reg`

## Requirements
- R1: A synchronous active-high reset clears every bit of the state and deasserts `flush_req`. While reset is high, a write request has no effect.
- R2: A machine-window write (`wr_sup`=0) updates only the writable bits below, and every other bit keeps its value. This includes the machine previous-privilege field (bits 12:11) and the upper bits of a 64-bit word.
  - supervisor interrupt enable, bit 1
  - machine interrupt enable, bit 3
  - supervisor previous interrupt enable, bit 5
  - machine previous interrupt enable, bit 7
  - supervisor previous privilege, bit 8
  - floating-point state, bits 14:13
  - modify-privilege, bit 17
  - protect-user-memory, bit 18
- R3: The extension state field (bits 16:15) is written only when `EXT_PRESENT` is 1. Otherwise it stays at zero.
- R4: The translation mode field (bits 28:24) takes the written value only when that value is 0 (bare) or 8 (paged). Any other value leaves the field unchanged.
- R5: A supervisor-window write (`wr_sup`=1) replaces only bits 1, 5, 8, 14:13, 16:15 and 18 with the incoming data. The result is applied as a machine-window write, so R2, R3 and R4 still apply. Bits 3, 7, 17 and 28:24 are never changed by this path.
- R6: `sstatus_rd` shows only bits 1, 5, 8, 14:13, 16:15 and 18 of the state, plus the summary bit. All other bits read 0.
- R7: The summary bit of `sstatus_rd` is bit XLEN-1. It reads 1 exactly when the floating-point field or the extension field equals 2'b11.
- R8: `flush_req` is high for exactly the cycle after a write edge that changed any bit of the following. It is low in every other cycle.
  - the translation mode field, bits 28:24
  - the machine previous-privilege field, bits 12:11
  - the modify-privilege bit, bit 17
  - the protect-user-memory bit, bit 18
- R9: A write becomes visible on `mstatus_rd` right after the clock edge at which it is accepted. Both read ports follow the stored state combinationally. Without a write, the state holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request, accepted at the rising edge |
| wr_sup | input | 1 | Selects the window: 1 for supervisor, 0 for machine |
| wr_data | input | XLEN | Write data |
| mstatus_rd | output | XLEN | Full machine-window read value |
| sstatus_rd | output | XLEN | Supervisor-window read value with the summary bit |
| flush_req | output | 1 | One-cycle translation cache flush request |

## Verification
The bench builds two instances side by side and drives both from the same stimulus:
- XLEN=32 with `EXT_PRESENT`=1, where the extension field is writable and the summary bit sits at bit 31;
- XLEN=64 with `EXT_PRESENT`=0, where the extension field must stay clear and the summary bit moves to bit 63.

Together they let one sweep cover both variants of the write mask and both summary-bit positions. The sweep writes every single bit through both windows, every translation-mode code and all sixteen combinations of the two state fields. Pseudo-random words through mixed windows then show flush behaviour on changing and non-changing writes.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

  localparam int VM_LO = 24;
  localparam int VM_W  = 5;
  localparam int FS_LO = 13;
  localparam int XS_LO = 15;

  localparam logic [VM_W-1:0] VM_BARE  = 5'd0;
  localparam logic [VM_W-1:0] VM_PAGED = 5'd8;

  localparam logic [31:0] B_SIE  = 32'h0000_0002;
  localparam logic [31:0] B_MIE  = 32'h0000_0008;
  localparam logic [31:0] B_SPIE = 32'h0000_0020;
  localparam logic [31:0] B_MPIE = 32'h0000_0080;
  localparam logic [31:0] B_SPP  = 32'h0000_0100;
  localparam logic [31:0] F_MPP  = 32'h0000_1800;
  localparam logic [31:0] F_FS   = 32'h0000_6000;
  localparam logic [31:0] F_XS   = 32'h0001_8000;
  localparam logic [31:0] B_MPRV = 32'h0002_0000;
  localparam logic [31:0] B_PUM  = 32'h0004_0000;
  localparam logic [31:0] F_VM   = 32'h1F00_0000;

  localparam logic [31:0] MACH_WMASK_BASE =
    B_SIE | B_MIE | B_SPIE | B_MPIE | B_SPP | F_FS | B_MPRV | B_PUM;
  localparam logic [31:0] SUP_MASK =
    B_SIE | B_SPIE | B_SPP | F_FS | F_XS | B_PUM;
  localparam logic [31:0] XLATE_MASK = F_VM | F_MPP | B_MPRV | B_PUM;

  function automatic logic vm_supported(input logic [VM_W-1:0] code);
    return (code == VM_BARE) || (code == VM_PAGED);
  endfunction

endpackage

// File: rtl/pstat_write_path.sv
module pstat_write_path #(
  parameter int XLEN        = 32,
  parameter bit EXT_PRESENT = 1'b1
) (
  input  logic [XLEN-1:0] cur,
  input  logic [XLEN-1:0] wr_data,
  input  logic            wr_sup,
  output logic [XLEN-1:0] nxt
);
  import pstat_pkg::*;

  localparam logic [XLEN-1:0] SMASK = XLEN'(SUP_MASK);
  localparam int              VM_HI = VM_LO + VM_W - 1;

  logic [XLEN-1:0] wmask;
  logic [XLEN-1:0] merged;
  logic [XLEN-1:0] masked;

  generate
    if (EXT_PRESENT) begin : g_ext
      assign wmask = XLEN'(MACH_WMASK_BASE | F_XS);
    end else begin : g_noext
      assign wmask = XLEN'(MACH_WMASK_BASE);
    end
  endgenerate

  // Supervisor window merges into current contents, then follows machine rules
  assign merged = wr_sup ? ((cur & ~SMASK) | (wr_data & SMASK)) : wr_data;
  assign masked = (cur & ~wmask) | (merged & wmask);

  always_comb begin
    nxt = masked;
    if (vm_supported(merged[VM_HI:VM_LO]))
      nxt[VM_HI:VM_LO] = merged[VM_HI:VM_LO];
  end

endmodule

// File: rtl/pstat_flush_detect.sv
module pstat_flush_detect #(
  parameter int XLEN = 32
) (
  input  logic            wr_en,
  input  logic [XLEN-1:0] cur,
  input  logic [XLEN-1:0] nxt,
  output logic            flush_d
);
  import pstat_pkg::*;

  localparam logic [XLEN-1:0] XMASK = XLEN'(XLATE_MASK);

  assign flush_d = wr_en && (((cur ^ nxt) & XMASK) != '0);

endmodule

// File: rtl/pstat_sup_view.sv
module pstat_sup_view #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] mstat,
  output logic [XLEN-1:0] sview
);
  import pstat_pkg::*;

  localparam logic [XLEN-1:0] SMASK = XLEN'(SUP_MASK);
  localparam logic [XLEN-1:0] SDBIT = {1'b1, {(XLEN-1){1'b0}}};

  logic dirty;

  assign dirty = (mstat[FS_LO+1:FS_LO] == 2'b11) ||
                 (mstat[XS_LO+1:XS_LO] == 2'b11);

  always_comb begin
    sview = mstat & SMASK;
    sview[XLEN-1] = dirty;
  end

  AST_SVIEW_ONLY_MASKED: assert property (@(posedge clk) disable iff (rst)
    ((sview & ~(SMASK | SDBIT)) == '0)); // R6

  AST_SVIEW_FIELDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    ((sview & SMASK) == (mstat & SMASK))); // R6

endmodule

// File: rtl/priv_status_reg.sv
module priv_status_reg #(
  parameter int XLEN        = 32,
  parameter bit EXT_PRESENT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_sup,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] mstatus_rd,
  output logic [XLEN-1:0] sstatus_rd,
  output logic            flush_req
);
  import pstat_pkg::*;

  localparam logic [XLEN-1:0] XMASK = XLEN'(XLATE_MASK);
  localparam int              VM_HI = VM_LO + VM_W - 1;

  logic [XLEN-1:0] mstat_q;
  logic [XLEN-1:0] mstat_nxt;
  logic            flush_d;
  logic            flush_q;

  pstat_write_path #(.XLEN(XLEN), .EXT_PRESENT(EXT_PRESENT)) u_wpath (
    .cur     (mstat_q),
    .wr_data (wr_data),
    .wr_sup  (wr_sup),
    .nxt     (mstat_nxt)
  );

  pstat_flush_detect #(.XLEN(XLEN)) u_flush (
    .wr_en   (wr_en),
    .cur     (mstat_q),
    .nxt     (mstat_nxt),
    .flush_d (flush_d)
  );

  pstat_sup_view #(.XLEN(XLEN)) u_sview (
    .clk   (clk),
    .rst   (rst),
    .mstat (mstat_q),
    .sview (sstatus_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mstat_q <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= flush_d;
      if (wr_en)
        mstat_q <= mstat_nxt;
    end
  end

  assign mstatus_rd = mstat_q;
  assign flush_req  = flush_q;

  AST_VM_SUPPORTED: assert property (@(posedge clk) disable iff (rst)
    vm_supported(mstat_q[VM_HI:VM_LO])); // R4

  AST_MPP_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mstat_q[12:11])); // R2

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> $stable(mstat_q)); // R9

  AST_FLUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && flush_req) |-> $past(wr_en)); // R8

  AST_FLUSH_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (((mstat_q ^ $past(mstat_q)) & XMASK) != '0)) |-> flush_req); // R8

  AST_FLUSH_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && flush_req) |-> (((mstat_q ^ $past(mstat_q)) & XMASK) != '0)); // R8

endmodule

// File: tb/priv_status_reg_test.sv
module priv_status_reg_test;

  localparam int CLK_PERIOD = 10;

  localparam logic [63:0] WM   = 64'h0000_0000_0006_61AA;
  localparam logic [63:0] XSM  = 64'h0000_0000_0001_8000;
  localparam logic [63:0] SM   = 64'h0000_0000_0005_E122;
  localparam logic [63:0] FM   = 64'h0000_0000_1F06_1800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sup = 1'b0;
  logic [63:0] wd = '0;

  logic [31:0] m32, s32;
  logic [63:0] m64, s64;
  logic        f32, f64;

  int checks = 0;
  int errors = 0;

  logic [63:0] e32 = '0;
  logic [63:0] e64 = '0;
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_status_reg #(.XLEN(32), .EXT_PRESENT(1'b1)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sup(wr_sup),
    .wr_data(wd[31:0]), .mstatus_rd(m32), .sstatus_rd(s32), .flush_req(f32)
  );

  priv_status_reg #(.XLEN(64), .EXT_PRESENT(1'b0)) uut64 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sup(wr_sup),
    .wr_data(wd), .mstatus_rd(m64), .sstatus_rd(s64), .flush_req(f64)
  );

  function automatic logic [63:0] model_wr(input logic [63:0] cur, input logic [63:0] val,
                                           input bit ext, input bit sup);
    logic [63:0] v, m, n;
    v = sup ? ((cur & ~SM) | (val & SM)) : val;
    m = ext ? (WM | XSM) : WM;
    n = (cur & ~m) | (v & m);
    if (v[28:24] == 5'd0 || v[28:24] == 5'd8) n[28:24] = v[28:24];
    return n;
  endfunction

  function automatic logic [63:0] model_sv(input logic [63:0] m, input int xl);
    logic [63:0] s;
    s = m & SM;
    if (m[14:13] == 2'b11 || m[16:15] == 2'b11) s[xl-1] = 1'b1;
    return s;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input bit ef32, input bit ef64);
    chk({tag, " mstatus32"}, {32'h0, m32}, e32);
    chk({tag, " mstatus64"}, m64, e64);
    chk({tag, " R6/R7 sstatus32"}, {32'h0, s32}, model_sv(e32, 32));
    chk({tag, " R6/R7 sstatus64"}, s64, model_sv(e64, 64));
    chk({tag, " R8 flush32"}, {63'h0, f32}, {63'h0, ef32});
    chk({tag, " R8 flush64"}, {63'h0, f64}, {63'h0, ef64});
  endtask

  // Called at a negedge; write accepted at next posedge, checked at next negedge (R9)
  task automatic do_wr(input bit sup, input logic [63:0] d, input string tag);
    logic [63:0] n32, n64;
    bit x32, x64;
    n32 = model_wr(e32, {32'h0, d[31:0]}, 1'b1, sup);
    n64 = model_wr(e64, d, 1'b0, sup);
    x32 = ((e32 ^ n32) & FM) != 64'h0;
    x64 = ((e64 ^ n64) & FM) != 64'h0;
    wr_en = 1'b1; wr_sup = sup; wd = d;
    @(negedge clk);
    wr_en = 1'b0;
    e32 = n32; e64 = n64;
    check_all(tag, x32, x64);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    check_all(tag, 1'b0, 1'b0);
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: a write during reset is ignored
    wr_en = 1'b1; wd = '1; wr_sup = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    check_all("R1 reset", 1'b0, 1'b0);
    idle("R9 idle after reset");

    // R2/R3/R4: single-bit writes through the machine window
    for (int b = 0; b < 64; b++) begin
      do_wr(1'b0, 64'h1 << b, "R2/R3/R4 machine set bit");
      do_wr(1'b0, 64'h0, "R2/R3/R4 machine clear");
    end
    // R5: single-bit writes through the supervisor window
    do_wr(1'b0, 64'h0006_618A, "R5 preload");
    for (int b = 0; b < 64; b++) begin
      do_wr(1'b1, 64'h1 << b, "R5 supervisor set bit");
      do_wr(1'b1, 64'h0, "R5 supervisor clear");
    end
    idle("R9 hold");

    // R4/R8: every translation mode code, from each legal starting mode
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 32; v++) begin
        do_wr(1'b0, (s == 0) ? 64'h0 : 64'h0800_0000, "R4 mode base");
        do_wr(1'b0, 64'(v) << 24, "R4/R8 mode code");
      end
    end
    // R5: supervisor write cannot touch the mode field
    do_wr(1'b1, 64'h0800_0000, "R5 supervisor mode");

    // R7: all combinations of floating-point and extension fields
    for (int fs = 0; fs < 4; fs++) begin
      for (int xs = 0; xs < 4; xs++) begin
        do_wr(1'b1, (64'(fs) << 13) | (64'(xs) << 15), "R7 sweep sup");
        do_wr(1'b0, (64'(fs) << 13) | (64'(xs) << 15), "R3/R7 sweep mach");
      end
    end

    // R8: repeating the same value raises no flush
    do_wr(1'b0, 64'h0806_0000, "R8 set mprv pum");
    do_wr(1'b0, 64'h0806_0000, "R8 same value no flush");
    idle("R8 no flush idle");

    // Pseudo-random mixture of windows and values
    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      lcg = step(lcg);
      d[31:0] = lcg;
      lcg = step(lcg);
      d[63:32] = lcg;
      if (lcg[3]) d[28:24] = lcg[4] ? 5'd8 : 5'd0;
      do_wr(lcg[7], d, "R2/R5/R8 random");
      if (lcg[9:8] == 2'b00) idle("R9 random idle");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule